// File: doc/BRIEF.md
# Priority-Resolved Multi-Function Pin Mux

This block decides, for every pin of a chip, which of several candidate signals drives the pad. Each pin has a ranked list of candidate signals. Level 0 is the most important, and a final fallback slot comes after the last level. A candidate is enabled by one or more terms. Each term is the AND of a few field comparisons. A field comparison picks a 32-bit source word, masks it, shifts it down to the mask's lowest set bit, and tests the result for equality or inequality against a constant. The terms for one level are ORed. Among the enabled levels, the smallest-numbered one wins.

The source words come from two places. One is a bank of control registers that software writes over a simple register bus. The other is a strap word, which is captured from input pins during reset and cannot be changed afterwards. Both the descriptor tables and the fallback enables are fixed at elaboration through parameters. The selection itself is purely combinational from the register and strap state. The block reports the winning slot of each pin as a one-hot vector and as an encoded index. It also routes that slot's output value and output enable to the pad.

Top module: `pmx_top`

## Requirements
- R1: Control registers sit at byte offsets 0x0, 0x4 and 0x8 (word index = `bus_addr[7:2]`). A write with `bus_we` high updates the register at that clock edge. Reads through `bus_rdata` are combinational. All control registers are zero after reset.
- R2: The strap word reads back at offset 0xC. It takes the value of `strap_pins` at each clock edge while `rst_n` is low, and holds the value from the last such edge. A bus write to 0xC has no effect on it, and neither do `strap_pins` changes after reset.
- R3: A read of any word index above 3 (byte offset 0x10 and up) returns zero.
- R4: A descriptor takes `(word & mask) >> lowest_set_bit(mask)` and compares it with a constant, for equality or inequality. A 2-bit video-mode field at control word 2 bits [5:4] is tested both as "not 0" and as "equal to 3".
- R5: A term is true only if all of its used descriptors match. A level is enabled if any of its terms is true. A term that reads the strap word keeps its level enabled whatever the control registers hold.
- R6: The lowest-numbered enabled level is selected, and every level below it is not selected. One control bit may enable a high level together with other fields, and on its own a lower level. The lower level is selected only while those other fields fail.
- R7: If no level is enabled and the pin's fallback is enabled, the fallback slot (index 3) is selected. If no level is enabled and there is no fallback, the pin has no selection: its one-hot vector and its index are both zero.
- R8: Pin p reports on `active_onehot[p*4 +: 4]`, where bit k stands for level k and bit 3 stands for the fallback. It reports the same choice as a binary index on `active_index[p*2 +: 2]`.
- R9: `pad_out[p]` and `pad_oe[p]` equal `sig_out[p*4+k]` and `sig_oe[p*4+k]` for the selected slot k. Both are 0 when the pin has no selection.
- R10: The default table is as follows. Words 0, 1 and 2 are the control registers and "strap" is the strap word.
  - Pin 0: level 0 = word0[0]==1; fallback on.
  - Pin 1:
    - level 0 = word1[22]==1
    - level 1 = word0[4]==1
    - level 2 = word0[3]==1 & word1[15]==1 & word2[31]==0
    - fallback on.
  - Pin 2: level 0 = word0[12]==1 | strap[14]==1; fallback on.
  - Pin 3:
    - level 0 = word2[5:4]!=0 & word1[17]==1
    - level 1 = word1[17]==1
    - level 2 = word2[5:4]==3 & word0[20]==1
    - no fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap capture while low |
| bus_addr | input | 8 | Byte address of register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| strap_pins | input | 32 | Strap input pins sampled during reset |
| sig_out | input | 16 | Per pin, per slot candidate output value |
| sig_oe | input | 16 | Per pin, per slot candidate output enable |
| pad_out | output | 4 | Routed output value per pin |
| pad_oe | output | 4 | Routed output enable per pin |
| active_onehot | output | 16 | Per pin one-hot selected slot |
| active_index | output | 8 | Per pin encoded selected slot |

## Verification
Two situations are hard to reach from the ports. The first is a level held by the strap word, because only a reset with chosen strap pins gets there. The bench therefore issues a second reset with strap bit 14 set, clears the control registers, and then tries to override the strap through the bus. The second is the third level of pin 3, because it wins only when the video field equals 3 while the shared enable bit is clear. The bench first sets every contributing bit so the higher levels win. It then clears the shared bit alone, and finally moves the field to 2 so that the pin falls to no selection.

// File: rtl/pmx_pkg.sv
// Package: shared descriptor type, table helpers and the default pin table.
// Assumes 32-bit source words and at most 8 source words (3-bit source index).
package pmx_pkg;

    localparam int WORD_W = 32;
    localparam int SRC_W  = 3;

    // One field comparison: source word, mask, constant, and compare sense.
    typedef struct packed {
        logic              used;
        logic              neq;
        logic [SRC_W-1:0]  src;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] want;
    } desc_t;

    localparam int DEF_PINS   = 4;
    localparam int DEF_LEVELS = 3;
    localparam int DEF_EXPRS  = 2;
    localparam int DEF_DESCS  = 3;
    localparam int DEF_CTRL   = 3;
    localparam int DEF_STRAP  = DEF_CTRL;
    localparam int DEF_TOTAL  = DEF_PINS * DEF_LEVELS * DEF_EXPRS * DEF_DESCS;

    typedef desc_t [DEF_TOTAL-1:0] tbl_t;

    // Position of the lowest set bit of a mask (0 for an empty mask).
    function automatic int low_bit(input logic [WORD_W-1:0] m);
        int r;
        r = 0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (m[i]) r = i;
        end
        return r;
    endfunction

    // Flat table slot of (pin, level, term, descriptor).
    function automatic int slot(input int p, input int l, input int e, input int d);
        return ((p * DEF_LEVELS + l) * DEF_EXPRS + e) * DEF_DESCS + d;
    endfunction

    // Single-bit equality descriptor.
    function automatic desc_t bit_is(input int src, input int idx, input logic val);
        desc_t r;
        r      = '0;
        r.used = 1'b1;
        r.src  = SRC_W'(src);
        r.mask = WORD_W'(1) << idx;
        r.want = {{(WORD_W-1){1'b0}}, val};
        return r;
    endfunction

    // Multi-bit field descriptor, equality or inequality.
    function automatic desc_t field_is(input int src, input logic [WORD_W-1:0] m,
                                       input logic [WORD_W-1:0] w, input logic ne);
        desc_t r;
        r      = '0;
        r.used = 1'b1;
        r.neq  = ne;
        r.src  = SRC_W'(src);
        r.mask = m;
        r.want = w;
        return r;
    endfunction

    // Default table for four pins.
    function automatic tbl_t default_table();
        tbl_t t;
        t = '0;
        // pin 0: single signal
        t[slot(0, 0, 0, 0)] = bit_is(0, 0, 1'b1);
        // pin 1: two registers, plus a three-way AND at level 2
        t[slot(1, 0, 0, 0)] = bit_is(1, 22, 1'b1);
        t[slot(1, 1, 0, 0)] = bit_is(0, 4, 1'b1);
        t[slot(1, 2, 0, 0)] = bit_is(0, 3, 1'b1);
        t[slot(1, 2, 0, 1)] = bit_is(1, 15, 1'b1);
        t[slot(1, 2, 0, 2)] = bit_is(2, 31, 1'b0);
        // pin 2: register bit OR strap bit
        t[slot(2, 0, 0, 0)] = bit_is(0, 12, 1'b1);
        t[slot(2, 0, 1, 0)] = bit_is(DEF_STRAP, 14, 1'b1);
        // pin 3: video-mode field with shared enable bit
        t[slot(3, 0, 0, 0)] = field_is(2, 32'h30, 32'd0, 1'b1);
        t[slot(3, 0, 0, 1)] = bit_is(1, 17, 1'b1);
        t[slot(3, 1, 0, 0)] = bit_is(1, 17, 1'b1);
        t[slot(3, 2, 0, 0)] = field_is(2, 32'h30, 32'd3, 1'b0);
        t[slot(3, 2, 0, 1)] = bit_is(0, 20, 1'b1);
        return t;
    endfunction

endpackage

// File: rtl/pmx_regbank.sv
// Module: control register bank with a reset-captured strap word.
// Does: holds NUM_CTRL writable 32-bit words and one read-only strap word,
//       exposes all of them as source words, and serves combinational reads.
// Assumes: word-aligned byte addresses; the strap word follows the control words.
module pmx_regbank #(
    parameter int NUM_CTRL = 3,
    parameter int ADDR_W   = 8,
    localparam int NUM_SRC = NUM_CTRL + 1,
    localparam int WIDX_W  = ADDR_W - 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [31:0]              strap_pins,
    output logic [NUM_SRC-1:0][31:0] src_words
);

    logic [NUM_CTRL-1:0][31:0] ctrl_q;
    logic [31:0]               strap_q;
    logic [WIDX_W-1:0]         widx;
    logic                      wr_hit;
    logic                      unused_low;

    assign widx       = bus_addr[ADDR_W-1:2];
    assign unused_low = ^bus_addr[1:0];
    assign wr_hit     = bus_we && (int'(widx) < NUM_CTRL);

    // Control words: clear in reset, load on an addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_hit) begin
            ctrl_q[widx] <= bus_wdata;
        end
    end

    // Strap word: follows the pins while in reset, frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_pins;
        end
    end

    // Source word vector: control words then strap.
    always_comb begin
        for (int i = 0; i < NUM_CTRL; i++) src_words[i] = ctrl_q[i];
        src_words[NUM_CTRL] = strap_q;
    end

    // Read mux: mapped words read back, everything else reads zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(widx) == i) bus_rdata = src_words[i];
        end
    end

    // R1: an addressed write is visible in the next cycle
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (ctrl_q[$past(widx)] == $past(bus_wdata)));

    // R2: the strap word never moves outside reset
    a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(strap_q));

    // R3: unmapped word offsets read zero
    a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(widx) >= NUM_SRC) |-> (bus_rdata == 32'd0));

endmodule

// File: rtl/pmx_desc_eval.sv
// Module: one field comparison.
// Does: selects a source word, masks and right-aligns the field, compares it.
// Assumes: descriptor is an elaboration-time constant; out-of-range source reads zero.
module pmx_desc_eval #(
    parameter int            NUM_SRC = 4,
    parameter pmx_pkg::desc_t DESC   = '0
) (
    input  logic [NUM_SRC-1:0][31:0] src_words,
    output logic                     hit
);

    localparam int SHIFT = pmx_pkg::low_bit(DESC.mask);

    logic [31:0] word;
    logic [31:0] field;

    // Source word selection fixed at elaboration.
    generate
        if (int'(DESC.src) < NUM_SRC) begin : g_src
            assign word = src_words[DESC.src];
        end else begin : g_nosrc
            assign word = '0;
        end
    endgenerate

    // Field extraction and comparison.
    assign field = (word & DESC.mask) >> SHIFT;
    assign hit   = DESC.neq ? (field != DESC.want) : (field == DESC.want);

endmodule

// File: rtl/pmx_pin_resolve.sv
// Module: per-pin priority resolver and pad router.
// Does: evaluates every term of every level, picks the lowest enabled level
//       (or the fallback), encodes the choice and routes that slot to the pad.
// Assumes: a term without any used descriptor is never true.
module pmx_pin_resolve #(
    parameter int  NUM_LEVELS = 3,
    parameter int  NUM_EXPRS  = 2,
    parameter int  NUM_DESCS  = 3,
    parameter int  NUM_SRC    = 4,
    parameter bit  FB_EN      = 1'b1,
    localparam int SLOTS      = NUM_LEVELS + 1,
    localparam int IDX_W      = $clog2(SLOTS),
    localparam int PER_PIN    = NUM_LEVELS * NUM_EXPRS * NUM_DESCS,
    parameter pmx_pkg::desc_t [PER_PIN-1:0] PIN_TBL = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0][31:0] src_words,
    input  logic [SLOTS-1:0]         sig_out,
    input  logic [SLOTS-1:0]         sig_oe,
    output logic [SLOTS-1:0]         onehot,
    output logic [IDX_W-1:0]         index,
    output logic                     pad_out,
    output logic                     pad_oe
);

    logic [NUM_LEVELS-1:0][NUM_EXPRS-1:0][NUM_DESCS-1:0] d_hit;
    logic [NUM_LEVELS-1:0][NUM_EXPRS-1:0]                e_true;
    logic [NUM_LEVELS-1:0]                               lvl_en;

    // True when any descriptor of the term at flat base is in use.
    function automatic logic term_live(input int base);
        logic r;
        r = 1'b0;
        for (int d = 0; d < NUM_DESCS; d++) r = r | PIN_TBL[base + d].used;
        return r;
    endfunction

    generate
        for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
            for (genvar e = 0; e < NUM_EXPRS; e++) begin : g_term
                localparam int BASE = (l * NUM_EXPRS + e) * NUM_DESCS;
                localparam logic LIVE = term_live(BASE);
                for (genvar d = 0; d < NUM_DESCS; d++) begin : g_desc
                    if (PIN_TBL[BASE + d].used) begin : g_used
                        pmx_desc_eval #(
                            .NUM_SRC (NUM_SRC),
                            .DESC    (PIN_TBL[BASE + d])
                        ) u_eval (
                            .src_words (src_words),
                            .hit       (d_hit[l][e][d])
                        );
                    end else begin : g_unused
                        assign d_hit[l][e][d] = 1'b1;
                    end
                end
                // Term: AND of its descriptors, only if it has any.
                assign e_true[l][e] = LIVE & (&d_hit[l][e]);
            end
            // Level: OR of its terms.
            assign lvl_en[l] = |e_true[l];
        end
    endgenerate

    // Priority pick: first enabled level wins, fallback only when none is.
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int k = 0; k < NUM_LEVELS; k++) begin
            onehot[k] = lvl_en[k] & ~blocked;
            blocked   = blocked | lvl_en[k];
        end
        onehot[NUM_LEVELS] = FB_EN & ~blocked;
    end

    // Binary encoding of the one-hot choice (zero when nothing selected).
    always_comb begin
        index = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (onehot[k]) index = IDX_W'(k);
        end
    end

    // Pad routing through the one-hot choice.
    assign pad_out = |(onehot & sig_out);
    assign pad_oe  = |(onehot & sig_oe);

    // R6: at most one slot is selected
    a_r6_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(onehot));

    // R6: an enabled level 0 always wins
    a_r6_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_en[0] |-> (onehot[0] && index == '0));

    // R7: with no level enabled the fallback decision is taken
    a_r7_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_en == '0) |-> (onehot[NUM_LEVELS] == FB_EN));

    // R9: an unselected pin drives nothing
    a_r9_idle_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (onehot == '0) |-> (!pad_out && !pad_oe && index == '0));

endmodule

// File: rtl/pmx_top.sv
// Module: multi-function pin mux top.
// Does: ties the register bank to one resolver per pin and flattens the
//       per-pin results onto plain vector ports.
// Assumes: DESC_TABLE holds NUM_PINS*NUM_LEVELS*NUM_EXPRS*NUM_DESCS descriptors,
//          pin-major, then level, term, descriptor.
module pmx_top #(
    parameter int  NUM_PINS   = pmx_pkg::DEF_PINS,
    parameter int  NUM_LEVELS = pmx_pkg::DEF_LEVELS,
    parameter int  NUM_EXPRS  = pmx_pkg::DEF_EXPRS,
    parameter int  NUM_DESCS  = pmx_pkg::DEF_DESCS,
    parameter int  NUM_CTRL   = pmx_pkg::DEF_CTRL,
    parameter int  ADDR_W     = 8,
    localparam int SLOTS      = NUM_LEVELS + 1,
    localparam int IDX_W      = $clog2(SLOTS),
    localparam int NUM_SRC    = NUM_CTRL + 1,
    localparam int PER_PIN    = NUM_LEVELS * NUM_EXPRS * NUM_DESCS,
    parameter pmx_pkg::desc_t [NUM_PINS*PER_PIN-1:0] DESC_TABLE = pmx_pkg::default_table(),
    parameter logic [NUM_PINS-1:0] FALLBACK_EN = 4'b0111
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [31:0]               strap_pins,
    input  logic [NUM_PINS*SLOTS-1:0] sig_out,
    input  logic [NUM_PINS*SLOTS-1:0] sig_oe,
    output logic [NUM_PINS-1:0]       pad_out,
    output logic [NUM_PINS-1:0]       pad_oe,
    output logic [NUM_PINS*SLOTS-1:0] active_onehot,
    output logic [NUM_PINS*IDX_W-1:0] active_index
);

    logic [NUM_SRC-1:0][31:0] src_words;

    pmx_regbank #(
        .NUM_CTRL (NUM_CTRL),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .strap_pins (strap_pins),
        .src_words  (src_words)
    );

    // One resolver per pin, each with its slice of the table.
    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            pmx_pin_resolve #(
                .NUM_LEVELS (NUM_LEVELS),
                .NUM_EXPRS  (NUM_EXPRS),
                .NUM_DESCS  (NUM_DESCS),
                .NUM_SRC    (NUM_SRC),
                .FB_EN      (FALLBACK_EN[p]),
                .PIN_TBL    (DESC_TABLE[p*PER_PIN +: PER_PIN])
            ) u_pin (
                .clk       (clk),
                .rst_n     (rst_n),
                .src_words (src_words),
                .sig_out   (sig_out[p*SLOTS +: SLOTS]),
                .sig_oe    (sig_oe[p*SLOTS +: SLOTS]),
                .onehot    (active_onehot[p*SLOTS +: SLOTS]),
                .index     (active_index[p*IDX_W +: IDX_W]),
                .pad_out   (pad_out[p]),
                .pad_oe    (pad_oe[p])
            );
        end
    endgenerate

endmodule

// File: tb/sim_pmx_top.sv
// Bench: scoreboard for the pin mux. The driver writes registers and pushes the
// expected choice of every pin; a monitor pops and compares at the falling edge.
module sim_pmx_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] strap_pins = '0;
    logic [15:0] sig_out = 16'hA5C3;
    logic [15:0] sig_oe  = 16'h3C96;
    logic [3:0]  pad_out, pad_oe;
    logic [15:0] active_onehot;
    logic [7:0]  active_index;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_r0, m_r1, m_r2, m_strap;

    typedef struct { int pin; int idx; string req; } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pmx_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_pins(strap_pins),
        .sig_out(sig_out), .sig_oe(sig_oe), .pad_out(pad_out), .pad_oe(pad_oe),
        .active_onehot(active_onehot), .active_index(active_index)
    );

    // Expected slot per pin from the default table (R10); -1 means no selection.
    function automatic int model_idx(input int p);
        logic [1:0] f;
        f = m_r2[5:4];
        case (p)
            0: return m_r0[0] ? 0 : 3;
            1: begin
                if (m_r1[22]) return 0;
                if (m_r0[4]) return 1;
                if (m_r0[3] && m_r1[15] && !m_r2[31]) return 2;
                return 3;
            end
            2: return (m_r0[12] || m_strap[14]) ? 0 : 3;
            default: begin
                if (f != 2'd0 && m_r1[17]) return 0;
                if (m_r1[17]) return 1;
                if (f == 2'd3 && m_r0[20]) return 2;
                return -1;
            end
        endcase
    endfunction

    // Driver: push the expected selection of every pin.
    task automatic expect_all(input string req);
        for (int p = 0; p < NP; p++) begin
            exp_t it;
            it.pin = p; it.idx = model_idx(p); it.req = req;
            sb_q.push_back(it);
        end
        @(negedge clk); #1;
    endtask

    // Monitor: compare selections and pad routing (R8, R9).
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t it;
            logic [3:0] e_oh, a_oh;
            logic [1:0] e_ix, a_ix;
            logic e_po, e_pe;
            it = sb_q.pop_front();
            e_oh = (it.idx < 0) ? 4'b0 : (4'b1 << it.idx);
            e_ix = (it.idx < 0) ? 2'd0 : 2'(it.idx);
            e_po = (it.idx < 0) ? 1'b0 : sig_out[it.pin*4 + it.idx];
            e_pe = (it.idx < 0) ? 1'b0 : sig_oe[it.pin*4 + it.idx];
            a_oh = active_onehot[it.pin*4 +: 4];
            a_ix = active_index[it.pin*2 +: 2];
            checks++;
            if (a_oh !== e_oh || a_ix !== e_ix || pad_out[it.pin] !== e_po || pad_oe[it.pin] !== e_pe) begin
                failures++;
                $display("FAIL %s R8 R9 pin%0d onehot=%b idx=%0d pad=%b%b expected onehot=%b idx=%0d pad=%b%b",
                         it.req, it.pin, a_oh, a_ix, pad_out[it.pin], pad_oe[it.pin],
                         e_oh, e_ix, e_po, e_pe);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
        case (a)
            8'h00: m_r0 = d;
            8'h04: m_r1 = d;
            8'h08: m_r2 = d;
            default: ;
        endcase
    endtask

    task automatic check_read(input logic [7:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        bus_addr = a; #1;
        checks++;
        if (bus_rdata !== e) begin
            failures++;
            $display("FAIL %s read 0x%0h got %h expected %h", req, a, bus_rdata, e);
        end
    endtask

    task automatic do_reset(input logic [31:0] s);
        @(negedge clk);
        rst_n = 1'b0; strap_pins = s;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        strap_pins = ~s;
        m_r0 = '0; m_r1 = '0; m_r2 = '0; m_strap = s;
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset(32'h0000_1234);
        // R1 reset values; R2 strap capture
        check_read(8'h00, 32'h0, "R1");
        check_read(8'h04, 32'h0, "R1");
        check_read(8'h08, 32'h0, "R1");
        check_read(8'h0C, 32'h0000_1234, "R2");
        // R3 unmapped offsets
        check_read(8'h10, 32'h0, "R3");
        check_read(8'hFC, 32'h0, "R3");
        // R7 reset selection: fallbacks and no selection on pin 3
        expect_all("R7");
        // R1 write and read back
        bus_write(8'h04, 32'hDEAD_0001);
        check_read(8'h04, 32'hDEAD_0001, "R1");
        bus_write(8'h04, 32'h0);
        // R2 write to strap ignored
        bus_write(8'h0C, 32'hFFFF_FFFF);
        check_read(8'h0C, 32'h0000_1234, "R2");
        // R10 pin 0 level 0
        bus_write(8'h00, 32'h1);
        expect_all("R10");
        // R4 field==0 with shared bit: pin 3 lower level
        bus_write(8'h04, 32'h0002_0000);
        expect_all("R6");
        // R4 field!=0 lifts pin 3 to level 0
        bus_write(8'h08, 32'h10);
        expect_all("R4");
        bus_write(8'h08, 32'h30);
        bus_write(8'h00, 32'h0010_0001);
        expect_all("R6");
        // R4 field==3 alone with shared bit clear: level 2
        bus_write(8'h04, 32'h0);
        expect_all("R4");
        // R7 field 2 with shared bit clear: no selection
        bus_write(8'h08, 32'h20);
        expect_all("R7");
        // R6 pin 1 level 1, then R5 three-way AND
        bus_write(8'h00, 32'h18);
        expect_all("R6");
        bus_write(8'h00, 32'h08);
        bus_write(8'h04, 32'h8000);
        expect_all("R5");
        bus_write(8'h08, 32'h8000_0020);
        expect_all("R5");
        bus_write(8'h04, 32'h0040_8000);
        expect_all("R6");
        // R5 register term of pin 2
        bus_write(8'h00, 32'h1000);
        expect_all("R5");
        bus_write(8'h00, 32'h0);
        expect_all("R5");
        // R9 routing with a new candidate pattern
        @(negedge clk);
        sig_out = 16'h5A3C; sig_oe = 16'hC369;
        expect_all("R9");
        // R2 R5 strap term holds pin 2 at level 0
        do_reset(32'h0000_4000);
        expect_all("R5");
        check_read(8'h0C, 32'h0000_4000, "R2");
        bus_write(8'h0C, 32'h0);
        bus_write(8'h00, 32'h0);
        check_read(8'h0C, 32'h0000_4000, "R2");
        expect_all("R2");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule